// File: doc/BRIEF.md
# Width-Adaptive Local Bus Lane Controller

This block produces the byte-lane strobes and data-phase control signals for the master side of a multiplexed 32-bit local bus. The memory regions on that bus can each be 8, 16 or 32 bits wide. The sequencing logic accepts one transfer request at a time. A request carries:

- the two low address bits,
- a byte mask,
- a read/write flag,
- a data/instruction flag,
- a beat count,
- the width of the region being accessed.

The block then walks the access through an address cycle, one or more data cycles and a recovery cycle. An active-low ready input ends each data cycle.

The four active-low byte-enable pins change meaning with the region width:

- On a 32-bit region, each pin gates one byte lane.
- On a 16-bit region, two pins act as high-byte and low-byte strobes, one pin is parked high, and one carries address bit 1.
- On an 8-bit region, two pins are parked high and two carry address bits 1 and 0.

When a pin carries address bits, those bits step forward on every accepted ready. Splitting unaligned transfers and driving the address and data values are handled elsewhere.

The sequencer has four states:

- IDLE: waits, and moves to ADDR (transition "accept") when a request is valid.
- ADDR: lasts one cycle, then moves to DATA (transition "open").
- DATA: stays in DATA while ready is high (transition "wait"). On a low ready with beats remaining, it stays and counts one beat down (transition "next"). On a low ready at the last beat, it moves to RECOVER (transition "close").
- RECOVER: lasts one cycle, then returns to IDLE (transition "release").

Top module: `bus_lane_ctrl`

## Requirements
- R1: While reset is held, lane_en_n is 4'b1111, data_en_n is 1, xmit is 0 and is_data is 0.
- R2: With width code 2'b10 or 2'b11 (32-bit), lane_en_n[i] is the inverse of req_mask[i] in the address cycle and in every data cycle, and it stays constant across all beats of a burst.
- R3: With width code 2'b01 (16-bit):
  - lane_en_n[3] is the inverse of req_mask[1] and acts as the high-byte strobe.
  - lane_en_n[0] is the inverse of req_mask[0] and acts as the low-byte strobe.
  - lane_en_n[2] is 1.
  - lane_en_n[1] carries address bit 1.
- R4: With width code 2'b00 (8-bit), lane_en_n[3:2] is 2'b11 and lane_en_n[1:0] carries address bits 1:0.
- R5: The address bits carried on the enable pins start at req_addr. On every ready accepted in a data cycle they advance by one byte on an 8-bit region (wrapping mod 4) and by two bytes on a 16-bit region (bit 1 wraps mod 2).
- R6: data_en_n goes low in the cycle after the address cycle. It returns high after the edge on which ready is sampled low for the last beat. There are req_beats+1 beats in total.
- R7: xmit is 0 for a read and 1 for a write. It is valid from the address cycle onward and never changes while data_en_n is low.
- R8: is_data is 1 for a data access and 0 for an instruction fetch, with the same timing as xmit.
- R9: In the idle and recovery cycles, lane_en_n is 4'b1111 and data_en_n is 1, while xmit and is_data keep their last values.
- R10: While ready_n is high in a data cycle, the sequencer stays in that data cycle and lane_en_n does not change.
- R11: A request presented while an access is in progress is ignored. It neither alters the outputs nor starts a further access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (accepted only when idle) |
| req_addr | input | 2 | Low two address bits of the access |
| req_mask | input | 4 | Active-high byte mask |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_beats | input | BEAT_W | Number of beats minus one |
| req_width | input | 2 | Region width: 00 = 8-bit, 01 = 16-bit, 1x = 32-bit |
| ready_n | input | 1 | Active-low ready that ends a data cycle |
| lane_en_n | output | 4 | Active-low byte enables / address bits |
| data_en_n | output | 1 | Active-low data-cycle indicator |
| xmit | output | 1 | Direction: 1 transmit, 0 receive |
| is_data | output | 1 | 1 data access, 0 instruction fetch |

## Verification
The bench issues accesses of each region width with chosen masks, start addresses and burst lengths. The aim is to show that the lane pins switch meaning correctly: constant lane strobes on 32-bit, split strobes plus a stepping bit on 16-bit, and a stepping two-bit counter on 8-bit that wraps past 3. Wait states are inserted between beats to separate stepping on accepted ready from stepping on every cycle. Read and write accesses, and data and instruction accesses, check that the direction and type outputs hold through idle. A request injected mid-access shows that a busy sequencer neither restarts nor changes direction.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES = 4;
    localparam int LA_W  = $clog2(LANES);

    localparam logic [1:0] WID_8  = 2'b00;
    localparam logic [1:0] WID_16 = 2'b01;

    typedef enum logic [1:0] {
        S_IDLE    = 2'b00,
        S_ADDR    = 2'b01,
        S_DATA    = 2'b10,
        S_RECOVER = 2'b11
    } seq_state_t;

endpackage

// File: rtl/lane_fsm.sv
module lane_fsm
    import lane_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic              ready_n,
    output seq_state_t        state,
    output logic              accept,
    output logic              step
);

    seq_state_t        state_nx;
    logic [BEAT_W-1:0] beats_left;

    assign accept = (state == S_IDLE) && req_valid;
    assign step   = (state == S_DATA) && !ready_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            beats_left <= '0;
        end else begin
            state <= state_nx;
            if (accept)
                beats_left <= req_beats;
            else if (step && beats_left != '0)
                beats_left <= beats_left - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = S_ADDR;
            S_ADDR:    state_nx = S_DATA;
            S_DATA:    if (step && beats_left == '0) state_nx = S_RECOVER;
            S_RECOVER: state_nx = S_IDLE;
        endcase
    end

endmodule

// File: rtl/lane_addr_step.sv
module lane_addr_step
    import lane_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [LA_W-1:0] start,
    input  logic [1:0]      width,
    input  logic            step,
    output logic [LA_W-1:0] cnt
);

    logic [LA_W-1:0] incr;

    always_comb begin
        unique case (width)
            WID_8:   incr = LA_W'(1);
            WID_16:  incr = LA_W'(2);
            default: incr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= start;
        else if (step)
            cnt <= cnt + incr;
    end

endmodule

// File: rtl/lane_encode.sv
module lane_encode
    import lane_pkg::*;
(
    input  logic             active,
    input  logic [1:0]       width,
    input  logic [LANES-1:0] mask,
    input  logic [LA_W-1:0]  cnt,
    output logic [LANES-1:0] lane_n
);

    logic [LANES-1:0] full_n;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign full_n[i] = ~mask[i];
    end

    always_comb begin
        lane_n = '1;
        if (active) begin
            unique case (width)
                WID_8: begin
                    lane_n[1:0] = cnt;
                end
                WID_16: begin
                    lane_n[3] = ~mask[1];
                    lane_n[1] = cnt[1];
                    lane_n[0] = ~mask[0];
                end
                default: lane_n = full_n;
            endcase
        end
    end

endmodule

// File: rtl/bus_lane_ctrl.sv
module bus_lane_ctrl
    import lane_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_addr,
    input  logic [3:0]        req_mask,
    input  logic              req_write,
    input  logic              req_data,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [1:0]        req_width,
    input  logic              ready_n,
    output logic [3:0]        lane_en_n,
    output logic              data_en_n,
    output logic              xmit,
    output logic              is_data
);

    seq_state_t      state;
    logic            accept;
    logic            step;
    logic [LA_W-1:0] cnt;
    logic [3:0]      mask_q;
    logic [1:0]      width_q;
    logic            active;

    lane_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_beats (req_beats),
        .ready_n   (ready_n),
        .state     (state),
        .accept    (accept),
        .step      (step)
    );

    lane_addr_step u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .start (req_addr),
        .width (width_q),
        .step  (step),
        .cnt   (cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            width_q <= '0;
            xmit    <= 1'b0;
            is_data <= 1'b0;
        end else if (accept) begin
            mask_q  <= req_mask;
            width_q <= req_width;
            xmit    <= req_write;
            is_data <= req_data;
        end
    end

    always_comb begin
        active    = 1'b0;
        data_en_n = 1'b1;
        unique case (state)
            S_IDLE:    ;
            S_ADDR:    active = 1'b1;
            S_DATA:    begin active = 1'b1; data_en_n = 1'b0; end
            S_RECOVER: ;
        endcase
    end

    lane_encode u_enc (
        .active (active),
        .width  (width_q),
        .mask   (mask_q),
        .cnt    (cnt),
        .lane_n (lane_en_n)
    );

endmodule

// File: rtl/lane_ctrl_chk.sv
module lane_ctrl_chk
    import lane_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] lane_en_n,
    input logic       data_en_n,
    input logic       xmit,
    input logic       is_data,
    input logic       ready_n,
    input seq_state_t state,
    input logic [1:0] width_q
);

    assert_dir_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n && $past(!data_en_n)) |-> $stable(xmit));

    assert_type_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n && $past(!data_en_n)) |-> $stable(is_data));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n && $past(!data_en_n) && $past(ready_n)) |-> $stable(lane_en_n));

    assert_wide_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_en_n && $past(!data_en_n) && width_q[1]) |-> $stable(lane_en_n));

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_RECOVER) |-> (lane_en_n == 4'hF && data_en_n));

    assert_half_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ADDR || state == S_DATA) && width_q == WID_16) |-> lane_en_n[2]);

    assert_byte_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ADDR || state == S_DATA) && width_q == WID_8) |-> (lane_en_n[3:2] == 2'b11));

    assert_den_after_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_en_n) |-> ($past(state) == S_ADDR));

endmodule

bind bus_lane_ctrl lane_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lane_en_n (lane_en_n),
    .data_en_n (data_en_n),
    .xmit      (xmit),
    .is_data   (is_data),
    .ready_n   (ready_n),
    .state     (state),
    .width_q   (width_q)
);

// File: tb/sim_bus_lane_ctrl.sv
`timescale 1ns/1ps
module sim_bus_lane_ctrl;

    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_addr;
    logic [3:0]    req_mask;
    logic          req_write;
    logic          req_data;
    logic [BW-1:0] req_beats;
    logic [1:0]    req_width;
    logic          ready_n;
    logic [3:0]    lane_en_n;
    logic          data_en_n;
    logic          xmit;
    logic          is_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bus_lane_ctrl #(.BEAT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_mask(req_mask), .req_write(req_write), .req_data(req_data),
        .req_beats(req_beats), .req_width(req_width), .ready_n(ready_n),
        .lane_en_n(lane_en_n), .data_en_n(data_en_n), .xmit(xmit), .is_data(is_data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_lane(input logic [1:0] w, input logic [1:0] a,
                                            input logic [3:0] m, input int b);
        logic [1:0] c;
        if (w == 2'b00) begin
            c = a + 2'(b);
            return {2'b11, c};
        end else if (w == 2'b01) begin
            c = a + 2'(2 * b);
            return {~m[1], 1'b1, c[1], ~m[0]};
        end
        return ~m;
    endfunction

    // one complete access; intrude injects a conflicting request mid-access (R11)
    task automatic do_access(input logic [1:0] w, input logic [1:0] a, input logic [3:0] m,
                             input logic wr, input logic dat, input int beats,
                             input int waits, input bit intrude, input string tag);
        @(negedge clk);
        req_valid = 1; req_width = w; req_addr = a; req_mask = m;
        req_write = wr; req_data = dat; req_beats = BW'(beats - 1);
        @(negedge clk);
        req_valid = 0;
        // address cycle
        chk(data_en_n == 1'b1, {tag, " R6 addr cycle den"}, data_en_n, 1);
        chk(lane_en_n == exp_lane(w, a, m, 0), {tag, " R2/R3/R4 addr lanes"}, lane_en_n, exp_lane(w, a, m, 0));
        chk(xmit == wr, {tag, " R7 dir in addr"}, xmit, wr);
        chk(is_data == dat, {tag, " R8 type in addr"}, is_data, dat);
        @(negedge clk);
        for (int b = 0; b < beats; b++) begin
            for (int k = 0; k <= waits; k++) begin
                chk(data_en_n == 1'b0, {tag, " R6 data cycle den"}, data_en_n, 0);
                chk(lane_en_n == exp_lane(w, a, m, b), {tag, " R5/R10 beat lanes"}, lane_en_n, exp_lane(w, a, m, b));
                chk(xmit == wr, {tag, " R7 dir in data"}, xmit, wr);
                chk(is_data == dat, {tag, " R8 type in data"}, is_data, dat);
                if (intrude && b == 0 && k == 0) begin
                    req_valid = 1; req_write = ~wr; req_data = ~dat; req_width = 2'b10;
                end else begin
                    req_valid = 0;
                end
                ready_n = (k == waits) ? 1'b0 : 1'b1;
                @(negedge clk);
            end
        end
        ready_n = 1'b1;
        req_valid = 0;
        // recovery cycle
        chk(data_en_n == 1'b1, {tag, " R6 den after last"}, data_en_n, 1);
        chk(lane_en_n == 4'hF, {tag, " R9 lanes recover"}, lane_en_n, 4'hF);
        @(negedge clk);
        chk(lane_en_n == 4'hF && data_en_n, {tag, " R9 idle outputs"}, {lane_en_n, data_en_n}, 5'h1F);
        chk(xmit == wr, {tag, " R9 dir held idle"}, xmit, wr);
        chk(is_data == dat, {tag, " R9 type held idle"}, is_data, dat);
        if (intrude) begin
            repeat (3) begin
                @(negedge clk);
                chk(data_en_n == 1'b1 && lane_en_n == 4'hF, {tag, " R11 no new access"},
                    {lane_en_n, data_en_n}, 5'h1F);
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 0; req_valid = 0; ready_n = 1;
        req_addr = 0; req_mask = 0; req_write = 0; req_data = 0; req_beats = 0; req_width = 0;
        repeat (3) @(negedge clk);
        chk(lane_en_n == 4'hF, "R1 reset lanes", lane_en_n, 4'hF);
        chk(data_en_n == 1'b1, "R1 reset den", data_en_n, 1);
        chk(xmit == 1'b0 && is_data == 1'b0, "R1 reset dir/type", {xmit, is_data}, 0);
        rst_n = 1;
    endtask

    task automatic t_wide_burst;   // R2
        do_access(2'b10, 2'b00, 4'b1111, 1'b0, 1'b1, 4, 0, 0, "w32 full read");
        do_access(2'b11, 2'b00, 4'b0110, 1'b1, 1'b1, 3, 1, 0, "w32 partial write");
    endtask

    task automatic t_half;         // R3, R5
        do_access(2'b01, 2'b10, 4'b0011, 1'b1, 1'b1, 3, 0, 0, "w16 wrap");
        do_access(2'b01, 2'b00, 4'b0001, 1'b0, 1'b1, 1, 0, 0, "w16 low only");
    endtask

    task automatic t_byte;         // R4, R5
        do_access(2'b00, 2'b10, 4'b0001, 1'b0, 1'b1, 4, 0, 0, "w8 wrap");
        do_access(2'b00, 2'b01, 4'b0001, 1'b1, 1'b1, 2, 2, 0, "w8 waits");
    endtask

    task automatic t_fetch;        // R8
        do_access(2'b10, 2'b00, 4'b1111, 1'b0, 1'b0, 2, 1, 0, "w32 fetch");
    endtask

    task automatic t_busy;         // R11
        do_access(2'b00, 2'b00, 4'b0001, 1'b0, 1'b1, 3, 1, 1, "busy ignore");
    endtask

    initial begin
        t_reset();
        t_wide_burst();
        t_half();
        t_byte();
        t_fetch();
        t_busy();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule